// File: doc/BRIEF.md
# Addend-Tuned Timestamp Clock Counter

This block keeps a free-running time-of-day count whose rate is set by a fractional addend instead of by the input clock directly. On every clock cycle a 32-bit addend is summed into a 32-bit fractional accumulator. Each carry out of that sum advances a 64-bit system time count by one tick, and one tick stands for 32 ns. The average tick rate is therefore addend / 2^32 ticks per clock. With a 50 MHz clock the reset addend of 0xA0000000 yields one tick every 32 ns on average. A frequency servo elsewhere trims the rate at run time by rewriting the addend within a few percent of that default.

Software uses a small word-wide register bus to reach the count. The bus has a select code, a write strobe and a read strobe. A new time is loaded in two writes. The low word is parked in a shadow register, and the write of the high word commits all 64 bits in one cycle. Reads work the other way round. Reading the low word freezes the matching high word in a holding register, so the high-word read that follows returns the same snapshot. A control bit holds every piece of time state at its default for as long as it stays set.

Top module: `tsclk_core`

## Requirements
- R1: After rst_n is released the addend reads 0xA0000000, the control register reads 0 and the system time starts from 0.
- R2: Select codes are 0 control (bit 0 is the soft reset), 1 addend, 2 time low word and 3 time high word. A read strobe loads bus_rdata at the next rising edge, and the value stays there until the next read.
- R3: In every cycle with no load and no soft reset, the system time either stays the same or rises by exactly one. Over N cycles the count advances by floor(N*addend/2^32) ticks, give or take one.
- R4: When the soft reset is released with the default addend, the time read after k further cycles is exactly floor(k*5/8).
- R5: A write to the time low word only updates the shadow register. The readable time does not change.
- R6: A write to the time high word loads the system time with {written word, shadow} in a single cycle.
- R7: If a carry occurs in the same cycle as a time load, the carry is dropped. The loaded value appears unchanged.
- R8: A read of the low word latches the high word of the same snapshot. A later read of the high word returns that latched value, even if the live count has since rolled into its high word.
- R9: While control bit 0 is 1, the time, accumulator, shadow and hold registers are held at 0 and the addend is held at 0xA0000000. Writes to the addend or the time have no effect, but the control register can still be read and written.
- R10: A tick carries from the low 32 bits of the system time into the high 32 bits.
- R11: A new addend takes effect from the cycle after its write and sets the tick rate from then on. An addend of 0 stops the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 2 | Register select code |
| bus_wdata | input | 32 | Write data word |
| bus_rdata | output | 32 | Registered read data word |

## Verification
The assertions assume a single bus master. They also assume that the software follows the two-step load order: the low word is written before the high word, and nothing else writes the shadow in between. The bench only issues loads as an adjacent low/high pair. The bench drives each strobe for exactly one cycle and never asserts read and write together. Checks that depend on the addend are made only after the new addend has been in place for at least one cycle.

// File: rtl/tsclk_pkg.sv
package tsclk_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ADDEND = 2'd1,
    SEL_TLO    = 2'd2,
    SEL_THI    = 2'd3
  } sel_e;
endpackage

// File: rtl/tsclk_accum.sv
module tsclk_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] addend,
  output logic              tick
);
  localparam int SUM_W = WORD_W + 1;

  function automatic logic [SUM_W-1:0] acc_add(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [WORD_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum  = acc_add(acc_q, addend);
  assign tick = sum[SUM_W-1] & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= sum[WORD_W-1:0];
  end
endmodule

// File: rtl/tsclk_timecnt.sv
module tsclk_timecnt #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  function automatic logic [TIME_W-1:0] next_time(input logic [TIME_W-1:0] cur,
                                                  input logic inc);
    return cur + {{(TIME_W-1){1'b0}}, inc};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     time_q <= '0;
    else if (clr)   time_q <= '0;
    else if (load)  time_q <= load_val;
    else            time_q <= next_time(time_q, tick);
  end
endmodule

// File: rtl/tsclk_regif.sv
module tsclk_regif
  import tsclk_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter logic [WORD_W-1:0] DEF_ADDEND = 32'hA000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [SEL_W-1:0]    bus_sel,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [2*WORD_W-1:0] time_q,
  output logic                soft_rst,
  output logic [WORD_W-1:0]   addend_q,
  output logic                load_time,
  output logic [2*WORD_W-1:0] load_val,
  output logic [WORD_W-1:0]   shadow_q,
  output logic [WORD_W-1:0]   hold_q
);
  localparam int TIME_W = 2 * WORD_W;

  logic ctrl_q;
  logic wr_ctrl, wr_add, wr_lo, wr_hi, rd_lo;

  assign wr_ctrl   = bus_wr && (bus_sel == SEL_CTRL);
  assign wr_add    = bus_wr && (bus_sel == SEL_ADDEND) && !ctrl_q;
  assign wr_lo     = bus_wr && (bus_sel == SEL_TLO)    && !ctrl_q;
  assign wr_hi     = bus_wr && (bus_sel == SEL_THI)    && !ctrl_q;
  assign rd_lo     = bus_rd && (bus_sel == SEL_TLO);
  assign soft_rst  = ctrl_q;
  assign load_time = wr_hi;
  assign load_val  = {bus_wdata, shadow_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addend_q <= DEF_ADDEND;
    else if (ctrl_q) addend_q <= DEF_ADDEND;
    else if (wr_add) addend_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= '0;
    else if (ctrl_q) shadow_q <= '0;
    else if (wr_lo)  shadow_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (ctrl_q) hold_q <= '0;
    else if (rd_lo)  hold_q <= time_q[TIME_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_sel)
        SEL_CTRL:   bus_rdata <= {{(WORD_W-1){1'b0}}, ctrl_q};
        SEL_ADDEND: bus_rdata <= addend_q;
        SEL_TLO:    bus_rdata <= time_q[WORD_W-1:0];
        default:    bus_rdata <= hold_q;
      endcase
    end
  end
endmodule

// File: rtl/tsclk_core.sv
module tsclk_core
  import tsclk_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter logic [WORD_W-1:0] DEF_ADDEND = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int TIME_W = 2 * WORD_W;

  logic              soft_rst;
  logic              tick;
  logic              load_time;
  logic [TIME_W-1:0] load_val;
  logic [TIME_W-1:0] time_q;
  logic [WORD_W-1:0] addend_q;
  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] hold_q;

  tsclk_regif #(.WORD_W(WORD_W), .DEF_ADDEND(DEF_ADDEND)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_q(time_q), .soft_rst(soft_rst), .addend_q(addend_q),
    .load_time(load_time), .load_val(load_val),
    .shadow_q(shadow_q), .hold_q(hold_q)
  );

  tsclk_accum #(.WORD_W(WORD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .addend(addend_q), .tick(tick)
  );

  tsclk_timecnt #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick),
    .load(load_time), .load_val(load_val), .time_q(time_q)
  );
endmodule

// File: rtl/tsclk_core_chk.sv
module tsclk_core_chk
  import tsclk_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter logic [WORD_W-1:0] DEF_ADDEND = 32'hA000_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [SEL_W-1:0]    bus_sel,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic                soft_rst,
  input logic                load_time,
  input logic [2*WORD_W-1:0] time_q,
  input logic [WORD_W-1:0]   addend_q,
  input logic [WORD_W-1:0]   shadow_q,
  input logic [WORD_W-1:0]   hold_q
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_time && !soft_rst) |=>
      ((time_q == $past(time_q)) || (time_q == $past(time_q) + 1'b1)));

  assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_TLO && !soft_rst) |=> (shadow_q == $past(bus_wdata)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_time |=> (time_q == $past({bus_wdata, shadow_q})));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == SEL_THI) |=> (bus_rdata == $past(hold_q)));

  assert_srst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (time_q == '0 && addend_q == DEF_ADDEND && shadow_q == '0));
endmodule

bind tsclk_core tsclk_core_chk #(.WORD_W(WORD_W), .DEF_ADDEND(DEF_ADDEND)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .soft_rst(soft_rst), .load_time(load_time), .time_q(time_q),
  .addend_q(addend_q), .shadow_q(shadow_q), .hold_q(hold_q)
);

// File: tb/tsclk_core_tb.sv
`timescale 1ns/1ps
module tsclk_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tsclk_core u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // tasks are entered just after a falling edge; each uses exactly one rising edge
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    bus_rd = 1'b1; bus_sel = s;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, lo1, hi1, lo2, hi2;
    logic [31:0] adds [5];
    longint unsigned diff, expn;
    adds[0] = 32'hA000_0000; adds[1] = 32'hA800_0000; adds[2] = 32'h9800_0000;
    adds[3] = 32'h4000_0000; adds[4] = 32'hC000_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 addend", d, 32'hA000_0000);
    rd(2'd2, d); check("R1 time low small", d <= 32'd8, 1);
    rd(2'd3, d); check("R1 time high", d, 0);

    // R9 soft reset holds state and ignores writes
    wr(2'd0, 32'd1);
    idle(1);
    rd(2'd2, d); check("R9 time held zero", d, 0);
    rd(2'd0, d); check("R9 ctrl readable", d, 1);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); check("R9 addend write ignored", d, 32'hA000_0000);
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd9);
    rd(2'd2, d); check("R9 time load ignored", d, 0);
    rd(2'd3, d); check("R9 high ignored", d, 0);

    // R4 exact progression after release
    wr(2'd0, 32'd0);
    idle(37);
    rd(2'd2, d); check("R4 k=37", d, (37 * 5) / 8);
    rd(2'd3, d); check("R4 R8 high of snapshot", d, 0);
    wr(2'd0, 32'd1);
    wr(2'd0, 32'd0);
    idle(1000);
    rd(2'd2, d); check("R4 k=1000", d, 625);

    // R11 zero addend freezes, R5 shadow, R6 commit
    wr(2'd1, 32'd0);
    rd(2'd1, d); check("R2 addend readback", d, 0);
    rd(2'd2, lo1);
    idle(20);
    rd(2'd2, d); check("R11 zero addend stops", d, lo1);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, d); check("R5 low write not visible", d, lo1);
    rd(2'd3, d); check("R5 high unchanged", d, 0);
    wr(2'd3, 32'h11);
    rd(2'd2, d); check("R6 low committed", d, 32'hDEAD_BEEF);
    rd(2'd3, d); check("R6 high committed", d, 32'h11);

    // R7 carry dropped on load (addend all ones: carry every cycle)
    wr(2'd1, 32'hFFFF_FFFF);
    idle(3);
    wr(2'd2, 32'h100);
    wr(2'd3, 32'h2);
    rd(2'd2, d); check("R7 load wins over carry", d, 32'h100);
    rd(2'd3, d); check("R7 high", d, 32'h2);

    // R10 word carry
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'h5);
    rd(2'd2, d); check("R7 load low exact", d, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R10 low wraps", d, 0);
    rd(2'd3, d); check("R10 high incremented", d, 32'h6);

    // R8 hold keeps snapshot across rollover
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'h7);
    rd(2'd2, d); check("R8 low snapshot", d, 32'hFFFF_FFFE);
    idle(3);
    rd(2'd3, d); check("R8 held high", d, 32'h7);
    rd(2'd2, d); check("R10 live low", d, 32'h3);
    rd(2'd3, d); check("R10 live high", d, 32'h8);

    // R3 R11 average rate for several addends
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, adds[i]);
      rd(2'd2, lo1); rd(2'd3, hi1);
      idle(4000);
      rd(2'd2, lo2); rd(2'd3, hi2);
      diff = {hi2, lo2} - {hi1, lo1};
      expn = (longint'(4002) * longint'(adds[i])) >> 32;
      total++;
      if (!(diff + 1 >= expn && diff <= expn + 1)) begin
        bad++;
        $display("FAIL R3 R11 rate addend=0x%0h actual=%0d expected=%0d", adds[i], diff, expn);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule